// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer

This block is a watchdog peripheral that sits behind a small synchronous register port. Software programs a timeout in whole seconds, sets the run bit, and then keeps writing a restart bit before the countdown runs out. An internal prescaler turns the core clock into a one-cycle strobe per second, and the countdown drops by one on each strobe. When the last second elapses while the block is running, it raises a one-cycle request on one of two outputs: a system-reset request or a power-off request. A control bit picks which one. In the same cycle the run bit clears and a sticky "expired" flag is set.

The register window is two 32-bit words, and address bit 2 selects between them. Word 0 (control/status) uses these bits: bit 0 is run, bit 1 is the expired flag, bit 2 selects power-off, bit 3 reads as idle (the inverse of run), and bit 7 is the write-only restart strobe. Word 1 holds the reload value. The expired flag sits on the power-on reset only. The system reset that the block's own request produces therefore leaves the flag intact, so software can see why the machine restarted. The whole function is gated by a watchdog enable input, and the register port is also gated by a separate access-enable input.

Top module: `wdt_timer`

## Requirements
- R1: After power-on reset the control word reads 0x08 (idle set, all else clear), the reload word reads DEF_TIMEOUT, and both request outputs are low.
- R2: A write to the reload word (address bit 2 = 1) stores write-data bits [9:0]. A stored value of zero is replaced by 1. The word reads back zero-extended. Address bits other than bit 2 are ignored, so address bit 2 = 0 selects the control word.
- R3: In the control word, bit 0 (run) and bit 2 (power-off select) are writable. Bit 3 reads as the inverse of run. Bits 7..4 and 31..8 always read 0, and the restart bit 7 is never held.
- R4: Writing bit 7 = 1 together with run = 1 reloads the countdown from the reload word and restarts the second phase. With a reload value of N and a prescaler divisor of D, the request pulse appears exactly N*D cycles after the clock edge that took the write.
- R5: Writing the reload word while a countdown is in progress does not change that countdown. The new value takes effect only at the next restart.
- R6: Clearing run freezes the remaining seconds and discards the partial second. Setting run again without a restart resumes from the remaining seconds: the pulse comes remaining*D cycles after the resume edge.
- R7: On expiry, exactly one output pulses high for exactly one cycle. rst_req fires when power-off select is 0, and pwroff_req fires when it is 1.
- R8: In the cycle the request pulse is high, run reads 0 and the expired flag (bit 1) reads 1.
- R9: The expired flag survives sys_rst_n, which resets every other register. Only por_n, or a control write with bit 1 = 1, clears it. A control write with bit 1 = 0 leaves it unchanged.
- R10: While wd_en is low, the countdown and prescaler hold their state, so expiry is delayed by exactly the number of low cycles. Register writes are ignored and reads return 0.
- R11: While reg_acc_en is low, register writes are ignored and reads return 0, but the countdown continues.
- R12: Read data is registered. bus_rdata changes on the clock edge that takes a read request and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears everything |
| sys_rst_n | input | 1 | System reset, active low, asynchronous; keeps the expired flag |
| wd_en | input | 1 | Watchdog function enable |
| reg_acc_en | input | 1 | Register port enable |
| bus_sel | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address in the window; bit 2 selects the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read |
| rst_req | output | 1 | One-cycle system-reset request on expiry |
| pwroff_req | output | 1 | One-cycle power-off request on expiry |

## Verification
The assertions assume that every bus input carries a known value at each clock edge, that each access lasts exactly one cycle, and that the two resets are driven low only when no access is in flight. The stimulus meets these assumptions by changing every input on the falling clock edge and by issuing accesses through tasks that hold bus_sel high for a single cycle. The assertions also assume the restart strobe can reach the countdown only while both enables are high. The stimulus tests this directly: it attempts control writes with each enable low and confirms that they have no effect.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // control/status word bit positions
  localparam int unsigned CTL_RUN    = 0;
  localparam int unsigned CTL_FIRED  = 1;
  localparam int unsigned CTL_PWROFF = 2;
  localparam int unsigned CTL_IDLE   = 3;
  localparam int unsigned CTL_TRIG   = 7;

  // byte-address bit that selects the word in the window
  localparam int unsigned WSEL_BIT   = 2;

  typedef enum logic {
    SEL_CTL = 1'b0,
    SEL_CNT = 1'b1
  } wsel_e;

  // decoded effect of a control-word write
  typedef struct packed {
    logic wr;
    logic run;
    logic clr_fired;
    logic pwroff;
    logic trig;
  } ctl_wr_t;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic hold,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_comb tick = !clear && !hold && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clear) begin
      pre_q <= '0;
    end else if (!hold) begin
      if (pre_q == LAST) pre_q <= '0;
      else               pre_q <= pre_q + PW'(1);
    end
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(DEF_TIMEOUT);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  // last second elapses on this strobe
  always_comb hit = tick && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= INIT;
    end else if (reload) begin
      cnt_q <= reload_val;
    end else if (tick) begin
      if (hit) cnt_q <= '0;
      else     cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/wdt_csr.sv
module wdt_csr
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              acc_ok,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              expire,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_q,
  output logic              pwroff_q,
  output logic              fired_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              reload
);
  localparam logic [CNT_W-1:0] INIT = CNT_W'(DEF_TIMEOUT);

  wsel_e            wsel;
  ctl_wr_t          cw;
  logic             cnt_wr;
  logic             rd_req;
  logic [CNT_W-1:0] wr_val;
  logic [DATA_W-1:0] ctl_word;
  logic [DATA_W-1:0] cnt_word;
  logic             unused_bits;

  assign unused_bits = ^{bus_addr, bus_wdata};

  always_comb begin
    wsel         = wsel_e'(bus_addr[WSEL_BIT]);
    cw.wr        = acc_ok && bus_sel && bus_we && (wsel == SEL_CTL);
    cw.run       = bus_wdata[CTL_RUN];
    cw.clr_fired = bus_wdata[CTL_FIRED];
    cw.pwroff    = bus_wdata[CTL_PWROFF];
    cw.trig      = bus_wdata[CTL_TRIG];
    cnt_wr       = acc_ok && bus_sel && bus_we && (wsel == SEL_CNT);
    rd_req       = bus_sel && !bus_we;
    wr_val       = bus_wdata[CNT_W-1:0];
    reload       = cw.wr && cw.trig;
  end

  // run and action select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      pwroff_q <= 1'b0;
    end else begin
      if (expire)     run_q <= 1'b0;
      else if (cw.wr) run_q <= cw.run;
      if (cw.wr)      pwroff_q <= cw.pwroff;
    end
  end

  // reload value, zero coerced to one second
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= INIT;
    end else if (cnt_wr) begin
      reload_q <= (wr_val == '0) ? CNT_W'(1) : wr_val;
    end
  end

  // expired flag lives on the power-on reset only
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fired_q <= 1'b0;
    end else if (expire) begin
      fired_q <= 1'b1;
    end else if (cw.wr && cw.clr_fired) begin
      fired_q <= 1'b0;
    end
  end

  always_comb begin
    ctl_word             = '0;
    ctl_word[CTL_RUN]    = run_q;
    ctl_word[CTL_FIRED]  = fired_q;
    ctl_word[CTL_PWROFF] = pwroff_q;
    ctl_word[CTL_IDLE]   = ~run_q;
    cnt_word             = '0;
    cnt_word[CNT_W-1:0]  = reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      if (!acc_ok)             bus_rdata <= '0;
      else if (wsel == SEL_CTL) bus_rdata <= ctl_word;
      else                     bus_rdata <= cnt_word;
    end
  end
endmodule

// File: rtl/wdt_action.sv
module wdt_action (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic pwroff_sel,
  output logic rst_req,
  output logic pwroff_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req    <= 1'b0;
      pwroff_req <= 1'b0;
    end else begin
      rst_req    <= hit && !pwroff_sel;
      pwroff_req <= hit &&  pwroff_sel;
    end
  end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned TICK_DIV    = 100_000_000,
  parameter int unsigned DEF_TIMEOUT = 60
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wd_en,
  input  logic              reg_acc_en,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req,
  output logic              pwroff_req
);
  logic             rst_n;
  logic             acc_ok;
  logic             ctl_run;
  logic             ctl_pwroff;
  logic             ctl_fired;
  logic [CNT_W-1:0] reload_val;
  logic             reload_pulse;
  logic             sec_tick;
  logic [CNT_W-1:0] cnt_live;
  logic             expire;

  assign rst_n  = por_n & sys_rst_n;
  assign acc_ok = wd_en & reg_acc_en;

  wdt_csr #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)
  ) u_csr (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .acc_ok(acc_ok),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .expire(expire), .bus_rdata(bus_rdata),
    .run_q(ctl_run), .pwroff_q(ctl_pwroff), .fired_q(ctl_fired),
    .reload_q(reload_val), .reload(reload_pulse)
  );

  wdt_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n),
    .clear(!ctl_run || reload_pulse),
    .hold(!wd_en),
    .tick(sec_tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick), .reload(reload_pulse),
    .reload_val(reload_val), .cnt_q(cnt_live), .hit(expire)
  );

  wdt_action u_act (
    .clk(clk), .rst_n(rst_n), .hit(expire), .pwroff_sel(ctl_pwroff),
    .rst_req(rst_req), .pwroff_req(pwroff_req)
  );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input logic              clk,
  input logic              por_n,
  input logic              sys_rst_n,
  input logic              wd_en,
  input logic              rd_req,
  input logic              fired_clr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rst_req,
  input logic              pwroff_req,
  input logic              run_q,
  input logic              pwroff_sel,
  input logic              fired_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              tick,
  input logic              reload
);
  logic all_rst_n;
  assign all_rst_n = por_n & sys_rst_n;

  // R4
  sec_step_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (tick && cnt_q > CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (!run_q && !reload) |=> $stable(cnt_q));

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    !(rst_req && pwroff_req));

  // R7
  short_pulse_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (rst_req || pwroff_req) |=> !(rst_req || pwroff_req));

  // R7
  rst_sel_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    rst_req |-> !$past(pwroff_sel));

  // R7
  pwr_sel_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    pwroff_req |-> $past(pwroff_sel));

  // R8
  expire_state_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    (rst_req || pwroff_req) |-> (!run_q && fired_q));

  // R9
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!por_n)
    (fired_q && !fired_clr) |=> fired_q);

  // R10
  freeze_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    !wd_en |=> $stable(cnt_q));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!all_rst_n)
    !rd_req |=> $stable(bus_rdata));
endmodule

bind wdt_timer wdt_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wd_en(wd_en),
  .rd_req(bus_sel & ~bus_we),
  .fired_clr(bus_sel & bus_we & ~bus_addr[2] & bus_wdata[1] & wd_en & reg_acc_en),
  .bus_rdata(bus_rdata), .rst_req(rst_req), .pwroff_req(pwroff_req),
  .run_q(ctl_run), .pwroff_sel(ctl_pwroff), .fired_q(ctl_fired),
  .cnt_q(cnt_live), .tick(sec_tick), .reload(reload_pulse)
);

// File: tb/wdt_timer_tb_top.sv
`timescale 1ns/1ps
module wdt_timer_tb_top;
  localparam int DIV = 4;
  localparam int DEF = 5;

  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b1, wd_en = 1'b1, reg_acc_en = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req, pwroff_req;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_timer #(.TICK_DIV(DIV), .DEF_TIMEOUT(DEF)) dut_i (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .wd_en(wd_en),
    .reg_acc_en(reg_acc_en), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rst_req(rst_req), .pwroff_req(pwroff_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  // waits for a request pulse; dt is measured from edge count t0
  task automatic wait_pulse(input int t0, output int dt, output logic r, output logic p);
    dt = -1; r = 0; p = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (rst_req || pwroff_req) begin
        dt = cyc - t0; r = rst_req; p = pwroff_req;
        break;
      end
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [31:0] d;
    int t0, dt, s, r0, elapsed;
    logic pr, pp;

    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset state
    check("R1 outputs", {30'd0, rst_req, pwroff_req}, 32'd0);
    rd(3'd0, d); check("R1 ctl", d, 32'h08);
    rd(3'd4, d); check("R1 reload", d, DEF);

    // R2 reload word storage and aliasing
    wr(3'd4, 32'd0);          rd(3'd4, d); check("R2 zero->1", d, 32'd1);
    wr(3'd4, 32'hFFFF_FC05);  rd(3'd4, d); check("R2 low bits", d, 32'd5);
    wr(3'd4, 32'd1023);       rd(3'd4, d); check("R2 max", d, 32'd1023);
    wr(3'd4, 32'h400);        rd(3'd4, d); check("R2 masked zero", d, 32'd1);
    wr(3'd6, 32'd7);          rd(3'd5, d); check("R2 alias cnt", d, 32'd7);
    rd(3'd3, d);              check("R2 alias ctl", d, 32'h08);

    // R3 field layout, restart never reads back
    wr(3'd0, 32'hFFFF_FFF4);  rd(3'd0, d); check("R3 fields", d, 32'h0C);
    wr(3'd0, 32'h0);          rd(3'd0, d); check("R3 clear", d, 32'h08);

    // R4 R7 R8 R9 sweep over reload values and both actions
    for (int act = 0; act < 2; act++) begin
      for (int n = 1; n <= 8; n++) begin
        wr(3'd4, n);
        wr(3'd0, 32'h81 | (act << 2));
        t0 = cyc;
        wait_pulse(t0, dt, pr, pp);
        check("R4 expiry delay", dt, n * DIV);
        check("R7 selected output", {30'd0, pr, pp}, (act == 0) ? 32'd2 : 32'd1);
        @(negedge clk);
        check("R7 one cycle", {30'd0, rst_req, pwroff_req}, 32'd0);
        rd(3'd0, d); check("R8 run clear fired set", d, 32'h0A | (act << 2));
        wr(3'd0, 32'h02 | (act << 2));
        rd(3'd0, d); check("R9 write-1 clears", d, 32'h08 | (act << 2));
      end
    end
    wr(3'd0, 32'h0);

    // R3 run readback while running
    wr(3'd4, 32'd100);
    wr(3'd0, 32'h81);
    rd(3'd0, d); check("R3 run reads 1 idle 0", d, 32'h01);
    wr(3'd0, 32'h00);

    // R5 reload write during countdown
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h81);
    t0 = cyc;
    wr(3'd4, 32'd9);
    wait_pulse(t0, dt, pr, pp);
    check("R5 countdown unchanged", dt, 3 * DIV);
    rd(3'd4, d); check("R5 new value stored", d, 32'd9);
    wr(3'd0, 32'h02);

    // R6 stop and resume
    wr(3'd4, 32'd4);
    wr(3'd0, 32'h81);
    t0 = cyc;
    while (cyc < t0 + 5) @(negedge clk);
    wr(3'd0, 32'h00);
    s = cyc;
    elapsed = (s - t0) / DIV;
    pr = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rst_req || pwroff_req) pr = 1;
    end
    check("R6 no expiry while stopped", {31'd0, pr}, 32'd0);
    wr(3'd0, 32'h01);
    r0 = cyc;
    wait_pulse(r0, dt, pr, pp);
    check("R6 resume remaining", dt, (4 - elapsed) * DIV);
    wr(3'd0, 32'h02);

    // R10 freeze while watchdog disabled
    wr(3'd4, 32'd2);
    wr(3'd0, 32'h81);
    t0 = cyc;
    @(negedge clk);
    wd_en = 1'b0;
    repeat (7) @(negedge clk);
    wd_en = 1'b1;
    wait_pulse(t0, dt, pr, pp);
    check("R10 delay by frozen cycles", dt, 2 * DIV + 7);
    wd_en = 1'b0;
    wr(3'd0, 32'h87);
    wr(3'd4, 32'd7);
    rd(3'd0, d); check("R10 read returns 0", d, 32'd0);
    wd_en = 1'b1;
    rd(3'd0, d); check("R10 ctl write ignored", d, 32'h0A);
    rd(3'd4, d); check("R10 reload write ignored", d, 32'd2);
    wr(3'd0, 32'h02);

    // R11 register access disabled, countdown continues
    wr(3'd4, 32'd3);
    wr(3'd0, 32'h81);
    t0 = cyc;
    reg_acc_en = 1'b0;
    wr(3'd0, 32'h00);
    rd(3'd0, d); check("R11 read returns 0", d, 32'd0);
    reg_acc_en = 1'b1;
    wait_pulse(t0, dt, pr, pp);
    check("R11 stop ignored", dt, 3 * DIV);
    wr(3'd0, 32'h02);

    // R12 read latency and hold
    rd(3'd4, d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd0;
    #1 check("R12 old data before edge", bus_rdata, 32'd3);
    @(negedge clk);
    bus_sel = 1'b0;
    check("R12 new data after edge", bus_rdata, 32'h08);
    repeat (5) @(negedge clk);
    check("R12 data holds", bus_rdata, 32'h08);

    // R9 sticky flag across system reset, cleared by power-on reset
    wr(3'd4, 32'd1);
    wr(3'd0, 32'h81);
    wait_pulse(cyc, dt, pr, pp);
    @(negedge clk);
    sys_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    sys_rst_n = 1'b1;
    rd(3'd0, d); check("R9 survives system reset", d, 32'h0A);
    rd(3'd4, d); check("R9 reload reset", d, DEF);
    wr(3'd0, 32'h00);
    rd(3'd0, d); check("R9 write-0 keeps flag", d, 32'h0A);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    rd(3'd0, d); check("R9 power-on clears", d, 32'h08);

    done = 1;
    summary();
  end
endmodule